// File: doc/BRIEF.md
# Data-Driven Hit Record Serializer

This block sends converted hit records from eight front-end channels over one serial line. It does not poll channels on a fixed schedule. A channel reaches the line only when it raises its request, which means it holds a converted hit. Each record carries four fields:

- the channel number;
- a 10-bit charge value;
- a 10-bit fine-time value;
- a 26-bit coarse timestamp, already Gray coded by the channel.

When several channels are waiting, a round-robin arbiter chooses the next one. The chosen record is framed and copied into a shift register. It then leaves the block one bit per clock, MSB first. After the last bit, the served channel gets a one-cycle done pulse. Sixteen channels use two independent instances.

A channel sets its fields and raises its request. It keeps both until it sees its done bit, and it drops the request in the cycle that bit is seen. The line rests at 0, so a single 1 marks the start of a frame.

Top module: `hit_serializer`

## Requirements
- R1: While reset is applied, and afterwards until a request arrives, `ser_out` is 0 and every bit of `hit_done` is 0.
- R2: When no request is pending and no frame is in flight, `ser_out` stays at 0.
- R3: A frame is 50 bits, one bit per clock, in this order: a start bit of 1, then the 3-bit channel number, the 10-bit charge, the 10-bit fine time and the 26-bit coarse time. Each field is sent MSB first, and the coarse time is passed on unchanged.
- R4: Suppose the line is idle and a request is present at a rising clock edge. The start bit is then driven in the cycle that follows that edge.
- R5: When more than one channel is waiting, the grant goes to the first requesting channel after the last channel served, counting upward and wrapping. Channel 0 has first turn after reset.
- R6: In the cycle right after a frame's final bit, exactly one `hit_done` bit is 1 for one cycle. That bit is the bit of the channel whose number the frame carried.
- R7: The two cycles between the final bit of a frame and the next start bit are 0 on the line.
- R8: Record fields are captured at grant. If a channel's inputs change while its frame is being sent, the bits already on their way are unaffected.
- R9: A channel sends a frame only while its request is high. Each request that is held until done produces exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_valid | input | 8 | Per-channel request: a converted hit is waiting |
| hit_charge | input | 80 | Charge values, channel i at bits [10i+9:10i] |
| hit_fine | input | 80 | Fine-time values, channel i at bits [10i+9:10i] |
| hit_coarse | input | 208 | Gray coarse timestamps, channel i at bits [26i+25:26i] |
| hit_done | output | 8 | One-cycle pulse to the channel just served |
| ser_out | output | 1 | Serial line, 0 when idle |

## Verification
A lone hit on one channel checks the latency from request to start bit and the bit order inside the frame. All eight channels raised in the same cycle check that grants rotate in round-robin order rather than follow a fixed priority. All-ones, all-zeros and alternating field values expose a field placed one position off or sent in reversed bit order. Two further cases target specific faults:

- Rewriting a channel's inputs in the middle of its frame shows whether the record was really captured at grant.
- A channel that re-requests as soon as it is served, while another channel waits, shows whether the pointer advance prevents starvation.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Transmit controller phases
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_GAP   = 2'd2
  } tx_state_e;

  localparam logic START_MARK = 1'b1;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            advance,
  output logic            req_any,
  output logic [CH_W-1:0] grant_id,
  output logic [CH_W-1:0] last_id
);

  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] last_d;
  logic            last_en;
  logic            found;
  logic [CH_W-1:0] pick;
  int              probe;

  // Search upward from the channel after the last one served
  always_comb begin
    found = 1'b0;
    pick  = last_q;
    probe = 0;
    for (int i = 1; i <= NCH; i++) begin
      probe = (int'(last_q) + i) % NCH;
      if (!found && req[probe]) begin
        found = 1'b1;
        pick  = CH_W'(probe);
      end
    end
  end

  assign last_en = advance;
  assign last_d  = pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= CH_W'(NCH - 1);
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  assign req_any  = |req;
  assign grant_id = pick;
  assign last_id  = last_q;

endmodule

// File: rtl/frame_packer.sv
module frame_packer import ser_pkg::*; #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH),
  parameter int Q_W  = 10,
  parameter int T_W  = 10,
  parameter int CT_W = 26,
  localparam int FRAME_W = 1 + CH_W + Q_W + T_W + CT_W
) (
  input  logic [NCH*Q_W-1:0]  hit_charge,
  input  logic [NCH*T_W-1:0]  hit_fine,
  input  logic [NCH*CT_W-1:0] hit_coarse,
  input  logic [CH_W-1:0]     sel,
  output logic [FRAME_W-1:0]  frame
);

  logic [Q_W-1:0]  charge_a [NCH];
  logic [T_W-1:0]  fine_a   [NCH];
  logic [CT_W-1:0] coarse_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign charge_a[g] = hit_charge[g*Q_W +: Q_W];
    assign fine_a[g]   = hit_fine[g*T_W +: T_W];
    assign coarse_a[g] = hit_coarse[g*CT_W +: CT_W];
  end

  // Start mark leads; fields follow, each MSB first
  assign frame = {START_MARK, sel, charge_a[sel], fine_a[sel], coarse_a[sel]};

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter import ser_pkg::*; #(
  parameter int FRAME_W = 50,
  parameter int CH_W    = 3,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_any,
  input  logic [CH_W-1:0]    grant_id,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               load,
  output logic               busy,
  output logic               done_fire,
  output logic [CH_W-1:0]    served_id,
  output logic               ser_out
);

  tx_state_e          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CH_W-1:0]    id_q, id_d;
  logic               sh_en;
  logic               cnt_en;
  logic               id_en;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    id_d  = id_q;
    load  = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (req_any) begin
          load  = 1'b1;
          sh_d  = frame_in;
          cnt_d = CNT_W'(FRAME_W - 1);
          id_d  = grant_id;
          st_d  = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        sh_d = {sh_q[FRAME_W-2:0], 1'b0};
        if (cnt_q == '0) begin
          st_d = TX_GAP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      TX_GAP: begin
        st_d = TX_IDLE;
      end
      default: begin
        st_d = TX_IDLE;
      end
    endcase
  end

  assign sh_en  = load || (st_q == TX_SHIFT);
  assign cnt_en = load || (st_q == TX_SHIFT);
  assign id_en  = load;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  assign busy      = (st_q != TX_IDLE);
  assign done_fire = (st_q == TX_GAP);
  assign served_id = id_q;
  assign ser_out   = sh_q[FRAME_W-1];

endmodule

// File: rtl/hit_serializer.sv
module hit_serializer #(
  parameter int NCH  = 8,
  parameter int Q_W  = 10,
  parameter int T_W  = 10,
  parameter int CT_W = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      hit_valid,
  input  logic [NCH*Q_W-1:0]  hit_charge,
  input  logic [NCH*T_W-1:0]  hit_fine,
  input  logic [NCH*CT_W-1:0] hit_coarse,
  output logic [NCH-1:0]      hit_done,
  output logic                ser_out
);

  localparam int CH_W    = $clog2(NCH);
  localparam int FRAME_W = 1 + CH_W + Q_W + T_W + CT_W;

  logic               rst_sync_n;
  logic               req_any;
  logic [CH_W-1:0]    grant_id;
  logic [CH_W-1:0]    last_id;
  logic [FRAME_W-1:0] frame;
  logic               tx_load;
  logic               tx_busy;
  logic               done_fire;
  logic [CH_W-1:0]    served_id;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rr_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (hit_valid),
    .advance  (tx_load),
    .req_any  (req_any),
    .grant_id (grant_id),
    .last_id  (last_id)
  );

  frame_packer #(
    .NCH(NCH), .CH_W(CH_W), .Q_W(Q_W), .T_W(T_W), .CT_W(CT_W)
  ) u_pack (
    .hit_charge (hit_charge),
    .hit_fine   (hit_fine),
    .hit_coarse (hit_coarse),
    .sel        (grant_id),
    .frame      (frame)
  );

  frame_shifter #(.FRAME_W(FRAME_W), .CH_W(CH_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_any   (req_any),
    .grant_id  (grant_id),
    .frame_in  (frame),
    .load      (tx_load),
    .busy      (tx_busy),
    .done_fire (done_fire),
    .served_id (served_id),
    .ser_out   (ser_out)
  );

  // Return the completion pulse to the served channel only
  for (genvar g = 0; g < NCH; g++) begin : g_done
    assign hit_done[g] = done_fire && (served_id == CH_W'(g));
  end

endmodule

// File: rtl/serializer_checker.sv
module serializer_checker #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  hit_valid,
  input logic [NCH-1:0]  hit_done,
  input logic            ser_out,
  input logic            tx_load,
  input logic            tx_busy,
  input logic [CH_W-1:0] grant_id,
  input logic [CH_W-1:0] last_id
);

  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_done)); // R6

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_done) |=> (hit_done == '0)); // R6

  AST_DONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_done) |-> !ser_out); // R7

  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_done) |=> !ser_out); // R7

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> ser_out); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && (hit_valid == '0)) |=> !ser_out); // R2

  AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && ($countones(hit_valid) > 1)) |-> (grant_id != last_id)); // R5

endmodule

bind hit_serializer serializer_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hit_valid (hit_valid),
  .hit_done  (hit_done),
  .ser_out   (ser_out),
  .tx_load   (tx_load),
  .tx_busy   (tx_busy),
  .grant_id  (grant_id),
  .last_id   (last_id)
);

// File: tb/tb_hit_serializer.sv
module tb_hit_serializer;

  localparam int NCH     = 8;
  localparam int QW      = 10;
  localparam int TW      = 10;
  localparam int CTW     = 26;
  localparam int FRAME_W = 50;

  logic                clk;
  logic                rst_n;
  logic [NCH-1:0]      hit_valid;
  logic [NCH*QW-1:0]   hit_charge;
  logic [NCH*TW-1:0]   hit_fine;
  logic [NCH*CTW-1:0]  hit_coarse;
  logic [NCH-1:0]      hit_done;
  logic                ser_out;

  // Channel model: request = set count differs from clear count
  int               set_cnt [NCH];
  int               clr_cnt [NCH];
  logic [QW-1:0]    ch_q    [NCH];
  logic [TW-1:0]    ch_t    [NCH];
  logic [CTW-1:0]   ch_c    [NCH];
  logic [FRAME_W-1:0] exp_rec [NCH];

  int m_checks, m_fails, mon_checks, mon_fails;
  int posted, received;

  hit_serializer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_charge (hit_charge),
    .hit_fine   (hit_fine),
    .hit_coarse (hit_coarse),
    .hit_done   (hit_done),
    .ser_out    (ser_out)
  );

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit_valid[i]              = (set_cnt[i] != clr_cnt[i]);
      hit_charge[i*QW +: QW]    = ch_q[i];
      hit_fine[i*TW +: TW]      = ch_t[i];
      hit_coarse[i*CTW +: CTW]  = ch_c[i];
    end
  end

  function automatic logic [NCH-1:0] vvec();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (set_cnt[i] != clr_cnt[i]);
    return v;
  endfunction

  function automatic logic [CTW-1:0] gray(input logic [CTW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_mon(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: stage one record and its expected frame
  task automatic load_hit(input int ch, input logic [QW-1:0] q, input logic [TW-1:0] t,
                          input logic [CTW-1:0] c);
    wait (set_cnt[ch] == clr_cnt[ch]);
    ch_q[ch] = q;
    ch_t[ch] = t;
    ch_c[ch] = c;
    exp_rec[ch] = {1'b1, 3'(ch), q, t, c};
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    @(posedge clk);
    #1;
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        set_cnt[i] = set_cnt[i] + 1;
        posted++;
      end
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 8000 && (vvec() != '0); n++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Monitor: deserialize, compare, check rotation and completion
  logic [FRAME_W-1:0] rx;
  int                 nb;
  bit                 in_frame, exp_done, gap2;
  int                 cur, last_ch, rr_exp;
  logic [NCH-1:0]     prev_v;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame = 0; exp_done = 0; gap2 = 0; nb = 0;
      last_ch = NCH - 1; rr_exp = 0; cur = 0;
      prev_v = '0;
    end else begin
      if (exp_done) begin
        chk_mon(hit_done == NCH'(1) << cur, "R6 done pulse", 64'(hit_done), 64'(NCH'(1) << cur));
        chk_mon(ser_out == 1'b0, "R7 first idle bit", 64'(ser_out), 64'd0);
        clr_cnt[cur] = clr_cnt[cur] + 1;
        exp_done = 0;
        gap2 = 1;
      end else begin
        if (hit_done != '0) chk_mon(1'b0, "R6 stray done", 64'(hit_done), 64'd0);
        if (gap2) begin
          chk_mon(ser_out == 1'b0, "R7 second idle bit", 64'(ser_out), 64'd0);
          gap2 = 0;
        end
        if (in_frame) begin
          rx = {rx[FRAME_W-2:0], ser_out};
          nb++;
          if (nb == FRAME_W) begin
            in_frame = 0;
            exp_done = 1;
            received++;
            cur = int'(rx[48:46]);
            chk_mon(rx == exp_rec[cur], "R3 R8 frame content", 64'(rx), 64'(exp_rec[cur]));
            chk_mon(cur == rr_exp, "R5 round-robin order", 64'(cur), 64'(rr_exp));
            last_ch = cur;
          end
        end else if (ser_out) begin
          rx = FRAME_W'(1);
          nb = 1;
          in_frame = 1;
          if (prev_v == '0) chk_mon(1'b0, "R9 frame without request", 64'd1, 64'd0);
          rr_exp = last_ch;
          for (int i = NCH; i >= 1; i--) begin
            if (prev_v[(last_ch + i) % NCH]) rr_exp = (last_ch + i) % NCH;
          end
        end
      end
      prev_v = vvec();
    end
  end

  task automatic run_tests();
    // Reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0, "R1 line in reset", 64'(ser_out), 64'd0);
    chk(hit_done == '0, "R1 done in reset", 64'(hit_done), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // Idle line with no request
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      chk(ser_out == 1'b0 && hit_done == '0, "R1 R2 idle after reset", 64'(ser_out), 64'd0);
    end
    // Single hit: latency and bit order
    load_hit(3, 10'h2A5, 10'h15A, gray(26'h12_3456));
    fire(8'h08);
    @(negedge clk);
    chk(ser_out == 1'b0, "R4 before grant edge", 64'(ser_out), 64'd0);
    @(negedge clk);
    chk(ser_out == 1'b1, "R4 start bit timing", 64'(ser_out), 64'd1);
    drain();
    // All channels at once: rotation from channel 4
    for (int c = 0; c < NCH; c++)
      load_hit(c, QW'(c * 37 + 5), TW'(1023 - c * 11), gray(CTW'(c * 1000003 + 7)));
    fire(8'hFF);
    drain();
    // Extreme field values
    load_hit(7, 10'h3FF, 10'h3FF, 26'h3FF_FFFF);
    load_hit(0, 10'h000, 10'h000, 26'h000_0000);
    load_hit(5, 10'h2AA, 10'h155, 26'h2AA_AAAA);
    fire(8'hA1);
    drain();
    // Inputs rewritten mid-frame must not disturb the frame
    load_hit(6, 10'h0F0, 10'h30F, gray(26'h0AB_CDEF));
    fire(8'h40);
    @(posedge ser_out);
    repeat (5) @(posedge clk);
    #1;
    ch_q[6] = 10'h10F;
    ch_t[6] = 10'h0F0;
    ch_c[6] = 26'h154_3210;
    drain();
    // Starvation test: channel 1 re-requests at once, channel 2 must be next
    load_hit(1, 10'h011, 10'h022, 26'h000_0033);
    load_hit(2, 10'h044, 10'h055, 26'h000_0066);
    fire(8'h06);
    load_hit(1, 10'h077, 10'h088, 26'h000_0099);
    fire(8'h02);
    load_hit(1, 10'h0AA, 10'h0BB, 26'h000_00CC);
    fire(8'h02);
    drain();
    chk(vvec() == '0, "R9 all requests served", 64'(vvec()), 64'd0);
    chk(posted == received, "R9 one frame per request", 64'(received), 64'(posted));
  endtask

  initial begin
    bit wd;
    clk = 1'b0;
    rst_n = 1'b0;
    wd = 0;
    m_checks = 0; m_fails = 0; mon_checks = 0; mon_fails = 0;
    posted = 0; received = 0;
    for (int i = 0; i < NCH; i++) begin
      set_cnt[i] = 0; clr_cnt[i] = 0;
      ch_q[i] = '0; ch_t[i] = '0; ch_c[i] = '0; exp_rec[i] = '0;
    end
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      m_checks++;
      m_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             m_checks + mon_checks, m_fails + mon_fails);
    $finish;
  end

endmodule